// File: doc/BRIEF.md
# Multichannel NCO Profile Selector

This block keeps sixteen 48-bit frequency tuning words for a downconverter NCO and chooses which one drives the NCO. Software fills the words through a byte-wide register port. It first writes a channel index and then writes the six bytes of a word. An update-mode bit sets when a written word takes effect. In continuous mode each byte lands in the indexed channel as soon as it is written. In staged mode the bytes collect in a holding word, and a transfer write copies that word into the indexed channel in one cycle.

A 4-bit source-mode field chooses where the active channel number comes from:

- a register field;
- four external select pins, passed through a two-flop synchronizer;
- a hop timer, which moves to the next channel after a programmed number of sample clocks.

The active channel index and its tuning word leave the block together, in the same cycle.

Register map (4-bit address, 8-bit data):

| Address | Contents |
|---|---|
| 0 | Source mode in [7:4], register channel in [3:0] |
| 1 | Staged flag in bit 7, write index in [3:0] |
| 2 to 7 | Tuning word bytes, least significant byte at address 2 |
| 8 to 13 | Hop period bytes, least significant byte at address 8 |
| 14 | Transfer strobe (any data) |
| 15 | Pin-select enable in bit 0 |

Top module: `nco_profile_sel`

## Requirements
- R1: While rst_ni is low, and right after it rises, chan_o is 0 and ftw_o is 0. Every channel word, every control field and the hop period reset to 0.
- R2: When the source mode is 0, chan_o takes the register channel field (address 0, bits [3:0]) on the clock edge after that field is written. Before that edge, chan_o keeps its old value.
- R3: When the staged flag (address 1, bit 7) is 0, a write to address 2+k puts the data byte into byte k (bits 8k+7 to 8k) of the channel named by the write index (address 1, bits [3:0]). If that channel is active, ftw_o shows the new byte in the cycle after the write edge.
- R4: When the staged flag is 1, writes to addresses 2 to 7 leave every channel word unchanged. A write to address 14 copies the 48-bit holding word, built from those byte writes, into the indexed channel in one step.
- R5: A write to one channel leaves the other fifteen channel words unchanged.
- R6: When the source mode is 1 to 11 and the pin-select enable (address 15, bit 0) is 1, chan_o follows gpio_i through a two-flop synchronizer. A change on gpio_i before edge A appears on chan_o after edge A+2 and not before.
- R7: When the source mode is 1 to 11 and the pin-select enable is 0, chan_o holds its value whatever gpio_i does.
- R8: When the source mode is 12 and the hop period P (address 8 is its least significant byte) is not zero, chan_o steps by one every P clocks and wraps from 15 to 0. The first step comes P edges after the edge that writes mode 12.
- R9: When the source mode is 12 and P is 0, chan_o holds.
- R10: When the source mode is 13 to 15, chan_o holds.
- R11: In every cycle, ftw_o equals the stored word of the channel shown on chan_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 8 | Register write data |
| gpio_i | input | 4 | External channel-select pins, asynchronous |
| ftw_o | output | 48 | Active tuning word |
| chan_o | output | 4 | Active channel index |

## Verification
Every channel is loaded with a different arithmetic pattern, and each one is then selected through the register path. This catches an index that is decoded wrongly or a write that spills into another channel. Single-byte writes in continuous mode and in staged mode separate the two update policies, and the transfer strobe must commit the whole word at once. All sixteen pin codes are swept across the eleven pin-select mode values and checked on both sides of the synchronizer delay, which exposes a wrong number of sync stages. Hop periods of 1, 3 and 258 are checked one edge before and at each hop, including the wrap from 15 to 0. The zero-period case, the reserved modes and pin mode with the pins disabled are each checked to hold the channel.

// File: rtl/nco_sel_pkg.sv
package nco_sel_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] A_SEL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_UPD  = 4'd1;
  localparam int unsigned       A_FTW0 = 2;
  localparam int unsigned       A_TMR0 = 8;
  localparam logic [ADDR_W-1:0] A_XFER = 4'd14;
  localparam logic [ADDR_W-1:0] A_GPEN = 4'd15;

  typedef enum logic [1:0] {SRC_REG, SRC_GPIO, SRC_TIMER, SRC_HOLD} src_e;

  function automatic src_e decode_src(input logic [3:0] mode);
    if (mode == 4'd0)                       return SRC_REG;
    else if (mode >= 4'd1 && mode <= 4'd11) return SRC_GPIO;
    else if (mode == 4'd12)                 return SRC_TIMER;
    else                                    return SRC_HOLD;
  endfunction
endpackage

// File: rtl/nco_cfg_regs.sv
module nco_cfg_regs
  import nco_sel_pkg::*;
#(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned FTW_W = 48,
  parameter int unsigned TMR_W = 48
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [BYTE_W-1:0]         wr_data_i,
  output logic [3:0]                sel_mode_o,
  output logic [$clog2(N_CH)-1:0]   reg_chan_o,
  output logic [$clog2(N_CH)-1:0]   wr_idx_o,
  output logic                      gpio_en_o,
  output logic [TMR_W-1:0]          tmr_period_o,
  output logic [FTW_W/BYTE_W-1:0]   bank_we_o,
  output logic [FTW_W-1:0]          bank_wdata_o
);
  localparam int unsigned IDX_W     = $clog2(N_CH);
  localparam int unsigned FTW_BYTES = FTW_W / BYTE_W;
  localparam int unsigned TMR_BYTES = TMR_W / BYTE_W;

  logic             staged_q;
  logic [FTW_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_mode_o   <= '0;
      reg_chan_o   <= '0;
      wr_idx_o     <= '0;
      staged_q     <= 1'b0;
      gpio_en_o    <= 1'b0;
      tmr_period_o <= '0;
      hold_q       <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_SEL) begin
        sel_mode_o <= wr_data_i[7:4];
        reg_chan_o <= wr_data_i[IDX_W-1:0];
      end
      if (wr_addr_i == A_UPD) begin
        staged_q <= wr_data_i[7];
        wr_idx_o <= wr_data_i[IDX_W-1:0];
      end
      if (wr_addr_i == A_GPEN) gpio_en_o <= wr_data_i[0];
      for (int k = 0; k < FTW_BYTES; k++)
        if (wr_addr_i == ADDR_W'(A_FTW0 + k)) hold_q[k*BYTE_W +: BYTE_W] <= wr_data_i;
      for (int k = 0; k < TMR_BYTES; k++)
        if (wr_addr_i == ADDR_W'(A_TMR0 + k)) tmr_period_o[k*BYTE_W +: BYTE_W] <= wr_data_i;
    end
  end

  // transfer commits the whole holding word; continuous mode writes one lane
  always_comb begin
    bank_we_o    = '0;
    bank_wdata_o = {FTW_BYTES{wr_data_i}};
    if (wr_en_i && wr_addr_i == A_XFER) begin
      bank_we_o    = '1;
      bank_wdata_o = hold_q;
    end else if (wr_en_i && !staged_q) begin
      for (int k = 0; k < FTW_BYTES; k++)
        if (wr_addr_i == ADDR_W'(A_FTW0 + k)) bank_we_o[k] = 1'b1;
    end
  end
endmodule

// File: rtl/nco_ftw_bank.sv
module nco_ftw_bank
  import nco_sel_pkg::*;
#(
  parameter int unsigned N_CH  = 16,
  parameter int unsigned FTW_W = 48
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [FTW_W/BYTE_W-1:0]   we_i,
  input  logic [$clog2(N_CH)-1:0]   widx_i,
  input  logic [FTW_W-1:0]          wdata_i,
  input  logic [$clog2(N_CH)-1:0]   ridx_i,
  output logic [FTW_W-1:0]          rdata_o
);
  localparam int unsigned IDX_W     = $clog2(N_CH);
  localparam int unsigned FTW_BYTES = FTW_W / BYTE_W;

  logic [FTW_W-1:0] words [N_CH];

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [FTW_W-1:0] w_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) w_q <= '0;
      else if (widx_i == IDX_W'(ch))
        for (int b = 0; b < FTW_BYTES; b++)
          if (we_i[b]) w_q[b*BYTE_W +: BYTE_W] <= wdata_i[b*BYTE_W +: BYTE_W];
    end
    assign words[ch] = w_q;
  end

  assign rdata_o = words[ridx_i];
endmodule

// File: rtl/nco_hop_timer.sv
module nco_hop_timer #(
  parameter int unsigned TMR_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [TMR_W-1:0] period_i,
  output logic             hop_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             run;

  assign run   = en_i && (period_i != '0);
  // >= keeps a period shrunk mid-count from stalling the timer
  assign hop_o = run && (cnt_q >= period_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (hop_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nco_chan_sel.sv
module nco_chan_sel
  import nco_sel_pkg::*;
#(
  parameter int unsigned N_CH        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [3:0]                mode_i,
  input  logic [$clog2(N_CH)-1:0]   reg_chan_i,
  input  logic [$clog2(N_CH)-1:0]   gpio_i,
  input  logic                      gpio_en_i,
  input  logic                      hop_i,
  output logic [$clog2(N_CH)-1:0]   gpio_sync_o,
  output logic [$clog2(N_CH)-1:0]   chan_o
);
  localparam int unsigned IDX_W = $clog2(N_CH);

  logic [IDX_W-1:0] sync_q [SYNC_STAGES];
  logic [IDX_W-1:0] chan_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= gpio_i;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end
  assign gpio_sync_o = sync_q[SYNC_STAGES-1];

  always_comb begin
    chan_d = chan_o;
    unique case (decode_src(mode_i))
      SRC_REG:   chan_d = reg_chan_i;
      SRC_GPIO:  if (gpio_en_i) chan_d = gpio_sync_o;
      SRC_TIMER: if (hop_i) chan_d = (chan_o == IDX_W'(N_CH - 1)) ? '0 : chan_o + 1'b1;
      default:   chan_d = chan_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chan_o <= '0;
    else         chan_o <= chan_d;
  end
endmodule

// File: rtl/nco_profile_sel.sv
module nco_profile_sel
  import nco_sel_pkg::*;
#(
  parameter int unsigned N_CH        = 16,
  parameter int unsigned FTW_W       = 48,
  parameter int unsigned TMR_W       = 48,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [BYTE_W-1:0]         wr_data_i,
  input  logic [$clog2(N_CH)-1:0]   gpio_i,
  output logic [FTW_W-1:0]          ftw_o,
  output logic [$clog2(N_CH)-1:0]   chan_o
);
  localparam int unsigned IDX_W     = $clog2(N_CH);
  localparam int unsigned FTW_BYTES = FTW_W / BYTE_W;

  logic [3:0]           sel_mode;
  logic [IDX_W-1:0]     reg_chan;
  logic [IDX_W-1:0]     wr_idx;
  logic                 gpio_en;
  logic [TMR_W-1:0]     tmr_period;
  logic [FTW_BYTES-1:0] bank_we;
  logic [FTW_W-1:0]     bank_wdata;
  logic                 hop;
  logic [IDX_W-1:0]     gpio_sync;

  nco_cfg_regs #(.N_CH(N_CH), .FTW_W(FTW_W), .TMR_W(TMR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .sel_mode_o(sel_mode), .reg_chan_o(reg_chan), .wr_idx_o(wr_idx),
    .gpio_en_o(gpio_en), .tmr_period_o(tmr_period),
    .bank_we_o(bank_we), .bank_wdata_o(bank_wdata)
  );

  nco_ftw_bank #(.N_CH(N_CH), .FTW_W(FTW_W)) u_bank (
    .clk_i, .rst_ni, .we_i(bank_we), .widx_i(wr_idx), .wdata_i(bank_wdata),
    .ridx_i(chan_o), .rdata_o(ftw_o)
  );

  nco_hop_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .en_i(decode_src(sel_mode) == SRC_TIMER),
    .period_i(tmr_period), .hop_o(hop)
  );

  nco_chan_sel #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_sel (
    .clk_i, .rst_ni, .mode_i(sel_mode), .reg_chan_i(reg_chan), .gpio_i,
    .gpio_en_i(gpio_en), .hop_i(hop), .gpio_sync_o(gpio_sync), .chan_o
  );
endmodule

// File: rtl/nco_profile_sel_chk.sv
module nco_profile_sel_chk #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned TMR_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [3:0]       mode_i,
  input logic [IDX_W-1:0] reg_chan_i,
  input logic             gpio_en_i,
  input logic [IDX_W-1:0] gpio_sync_i,
  input logic [TMR_W-1:0] period_i,
  input logic [IDX_W-1:0] chan_i
);
  logic gp_mode;
  assign gp_mode = (mode_i >= 4'd1) && (mode_i <= 4'd11);

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_chan: assert (chan_i == '0);

  a_r2_reg_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd0) |=> (chan_i == $past(reg_chan_i)));

  a_r6_gpio_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gp_mode && gpio_en_i) |=> (chan_i == $past(gpio_sync_i)));

  a_r7_gpio_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gp_mode && !gpio_en_i) |=> $stable(chan_i));

  a_r8_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd12) |=> (chan_i == $past(chan_i) || chan_i == IDX_W'($past(chan_i) + 1'b1)));

  a_r9_zero_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 4'd12 && period_i == '0) |=> $stable(chan_i));

  a_r10_reserved_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i >= 4'd13) |=> $stable(chan_i));
endmodule

bind nco_profile_sel nco_profile_sel_chk #(.IDX_W(IDX_W), .TMR_W(TMR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(sel_mode), .reg_chan_i(reg_chan),
  .gpio_en_i(gpio_en), .gpio_sync_i(gpio_sync), .period_i(tmr_period), .chan_i(chan_o)
);

// File: tb/sim_nco_profile_sel.sv
`timescale 1ns/1ps
module sim_nco_profile_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [3:0]  gpio;
  logic [47:0] ftw;
  logic [3:0]  chan;

  int checks = 0;
  int errors = 0;
  logic [47:0] exp_w [16];

  always #2.5 clk = ~clk;

  nco_profile_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .gpio_i(gpio), .ftw_o(ftw), .chan_o(chan)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_word(input logic [47:0] w);
    for (int b = 0; b < 6; b++) wr(4'(2 + b), w[b*8 +: 8]);
  endtask

  function automatic logic [47:0] pat(input int ch);
    logic [47:0] t;
    t = 48'(ch + 1);
    return (t * 48'h0000_9E37_79B9) ^ 48'hA5A5_0000_5A5A;
  endfunction

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 40000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] prev, cur, held;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; gpio = '0;
    repeat (3) @(negedge clk);
    chk("R1 chan in reset", 48'(chan), 48'd0);
    chk("R1 ftw in reset", ftw, 48'd0);
    rst_n = 1'b1;
    step(1);
    chk("R1 chan after reset", 48'(chan), 48'd0);

    // R3/R5: continuous load of every channel
    for (int ch = 0; ch < 16; ch++) begin
      wr(4'h1, 8'(ch));
      wr_word(pat(ch));
      exp_w[ch] = pat(ch);
    end

    // R2/R5/R11: register select sweep
    prev = 4'd0;
    for (int i = 0; i < 16; i++) begin
      cur = 4'((i * 7) % 16);
      wr(4'h0, {4'h0, cur});
      chk("R2 chan not early", 48'(chan), 48'(prev));
      step(1);
      chk("R2 chan reg select", 48'(chan), 48'(cur));
      chk("R5 word per channel", ftw, exp_w[cur]);
      prev = cur;
    end

    // R3: single byte write visible on active channel
    wr(4'h0, 8'h05); step(1);
    wr(4'h1, 8'h05);
    wr(4'h2, 8'h77);
    exp_w[5][7:0] = 8'h77;
    chk("R3 continuous byte", ftw, exp_w[5]);
    wr(4'h7, 8'hE1);
    exp_w[5][47:40] = 8'hE1;
    chk("R3 continuous top byte", ftw, exp_w[5]);

    // R4: staged writes wait for transfer
    wr(4'h1, 8'h85);
    wr_word(48'hC0FF_EE12_3456);
    chk("R4 staged no effect", ftw, exp_w[5]);
    wr(4'hE, 8'h00);
    exp_w[5] = 48'hC0FF_EE12_3456;
    chk("R4 transfer commit", ftw, exp_w[5]);
    wr(4'h0, 8'h06); step(1);
    chk("R5 neighbour intact", ftw, exp_w[6]);
    wr(4'h0, 8'h04); step(1);
    chk("R5 neighbour below intact", ftw, exp_w[4]);

    // R7: pins ignored while not enabled
    gpio = 4'd3;
    wr(4'h0, 8'h10);
    step(5);
    chk("R7 gpio disabled hold", 48'(chan), 48'd4);

    // R6: synchronized pin select across all codes and modes
    wr(4'hF, 8'h01);
    step(3);
    prev = 4'd3;
    chk("R6 gpio after enable", 48'(chan), 48'(prev));
    for (int v = 0; v < 16; v++) begin
      wr(4'h0, {4'(1 + v % 11), 4'h0});
      gpio = 4'(v);
      step(2);
      chk("R6 gpio sync delay", 48'(chan), 48'(prev));
      step(1);
      chk("R6 gpio select", 48'(chan), 48'(v));
      chk("R11 gpio word", ftw, exp_w[v]);
      prev = 4'(v);
    end

    // R9: zero period holds
    wr(4'h0, 8'h0E); step(1);
    wr(4'h0, 8'hC0);
    step(20);
    chk("R9 zero period hold", 48'(chan), 48'd14);

    // R8: period 3, wrap 15 -> 0
    wr(4'h0, 8'h0E); step(1);
    wr(4'h8, 8'h03);
    wr(4'h0, 8'hC0);
    cur = 4'd14;
    for (int k = 0; k < 20; k++) begin
      step(2);
      chk("R8 no early hop", 48'(chan), 48'(cur));
      step(1);
      cur = cur + 4'd1;
      chk("R8 hop period 3", 48'(chan), 48'(cur));
      chk("R11 timer word", ftw, exp_w[cur]);
    end

    // R8: period 1
    wr(4'h0, 8'h02); step(1);
    wr(4'h8, 8'h01);
    wr(4'h0, 8'hC0);
    cur = 4'd2;
    for (int k = 0; k < 18; k++) begin
      step(1);
      cur = cur + 4'd1;
      chk("R8 hop period 1", 48'(chan), 48'(cur));
    end

    // R8: multi-byte period 258
    wr(4'h0, 8'h07); step(1);
    wr(4'h8, 8'h02);
    wr(4'h9, 8'h01);
    wr(4'h0, 8'hC0);
    step(257);
    chk("R8 period 258 before", 48'(chan), 48'd7);
    step(1);
    chk("R8 period 258 hop", 48'(chan), 48'd8);

    // R10: reserved modes hold
    wr(4'h0, 8'hD0);
    held = chan;
    step(300);
    chk("R10 mode 13 hold", 48'(chan), 48'(held));
    wr(4'h0, 8'hF3);
    step(10);
    chk("R10 mode 15 hold", 48'(chan), 48'(held));
    chk("R11 held word", ftw, exp_w[held]);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule